// File: doc/BRIEF.md
# Locked Bus Hold Arbiter

This block sits beside the bus cycle sequencer of a processor bus interface. It drives the bus lock pin and decides when another master's hold request, or the internal refresh controller's request, may take the bus. A decoded lock-prefix strobe arms the lock. The pin then rises at the first phase-1 T1 state. It falls at the first phase-1 T1 state that follows the end of the locked instruction. While a lock sequence is in progress, requests are recorded in sticky pending flags and are not granted. This keeps a read-modify-write semaphore or a locked block move atomic.

Grants are issued only while the bus is idle between cycles. A pending refresh outranks a pending hold by default, and a parameter reverses that order. A hold acknowledge lasts as long as the hold request stays high. A refresh grant is a one-cycle pulse. Interrupts are never held back by the lock: the halt wake-up output follows halt and interrupt whether or not the bus is locked.

Top module: `lock_hold_arbiter`

## Requirements
- R1: After a cycle with `lock_pfx_i`=1, `lock_o` stays 0 until the first clock edge that samples `t1_i`=1 and `ph1_i`=1 together; `lock_o` is 1 from that edge on. `t1_i` high with `ph1_i` low does not assert it.
- R2: Once set, `lock_o` stays 1 through the locked instruction and through `instr_end_i`. It clears at the first edge after `instr_end_i` that samples `t1_i`=1 and `ph1_i`=1.
- R3: If `instr_end_i` arrives after the prefix but before any phase-1 T1 state, `lock_o` never rises.
- R4: A new `lock_pfx_i` while a release is awaited keeps `lock_o` at 1 without a gap across the next phase-1 T1 state.
- R5: From the prefix strobe until `lock_o` has cleared, no hold acknowledge rises and no refresh grant is issued. Requests made in that window are recorded and granted afterwards.
- R6: With `RFSH_OVER_HOLD`=1, a refresh and a hold pending together produce the refresh grant first and the acknowledge later. With 0, the acknowledge comes first and the refresh waits until the hold is released.
- R7: A one-cycle `rfsh_req_i` pulse stays pending until it is granted. `rfsh_gnt_o` is a single-cycle pulse, and no grant starts in a cycle where `bus_idle_i` is 0.
- R8: `hlda_o` drops one edge after `hold_req_i` goes low. A hold request withdrawn before it is granted produces no acknowledge.
- R9: `wake_o` is 1 exactly when `halt_i` and `intr_i` are both 1, including during a locked halt.
- R10: Reset (`rst_n`=0, asynchronous) forces `lock_o`, `hlda_o` and `rfsh_gnt_o` to 0 and clears all pending requests and lock state.
- R11: `hlda_o` and `rfsh_gnt_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_pfx_i | input | 1 | Lock-prefix instruction executed (one-cycle strobe) |
| instr_end_i | input | 1 | Current instruction finished executing (strobe) |
| t1_i | input | 1 | Bus sequencer is in T1 |
| ph1_i | input | 1 | Clock phase 1 of the current T-state |
| bus_idle_i | input | 1 | Bus is between cycles; grants may change |
| halt_i | input | 1 | Processor is in the halt state |
| intr_i | input | 1 | Interrupt request |
| hold_req_i | input | 1 | Bus hold request from another master (level) |
| rfsh_req_i | input | 1 | Refresh request (pulse, latched) |
| lock_o | output | 1 | Bus lock pin |
| hlda_o | output | 1 | Hold acknowledge |
| rfsh_gnt_o | output | 1 | Refresh grant pulse |
| wake_o | output | 1 | Halt exit on interrupt |

## Verification
The bench builds two copies of the block. Instance `dut` uses `RFSH_OVER_HOLD`=1 and carries the whole stimulus table. Instance `dut_alt` uses 0 and is observed only in the directed test where both requests are pending together. Only that pairing can show both grant orders, including the case where a refresh waits behind a held bus. The default instance is used to check the exact lock edges, a relock while a release is awaited, and a locked halt that an interrupt still ends.

// File: rtl/lha_pkg.sv
package lha_pkg;
   // Lock sequence: idle, prefix seen, locked instruction running,
   // instruction ended and waiting for the next T1 phase 1.
   typedef enum logic [1:0] {
      LS_IDLE    = 2'd0,
      LS_ARMED   = 2'd1,
      LS_RUN     = 2'd2,
      LS_RELEASE = 2'd3
   } lock_state_e;
endpackage

// File: rtl/lha_lock_seq.sv
module lha_lock_seq
   import lha_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pfx_i,
   input  logic end_i,
   input  logic edge_i,
   output logic lock_o,
   output logic busy_o
);
   lock_state_e st_q, st_d;
   logic        lock_q, lock_d;

   always_comb begin
      st_d   = st_q;
      lock_d = lock_q;
      unique case (st_q)
         LS_IDLE: begin
            if (pfx_i) st_d = LS_ARMED;
         end
         LS_ARMED: begin
            if (end_i) begin
               st_d = lock_q ? LS_RELEASE : LS_IDLE;
            end else if (edge_i) begin
               st_d   = LS_RUN;
               lock_d = 1'b1;
            end
         end
         LS_RUN: begin
            if (end_i) st_d = LS_RELEASE;
         end
         LS_RELEASE: begin
            if (pfx_i) begin
               st_d = LS_ARMED;
            end else if (edge_i) begin
               st_d   = LS_IDLE;
               lock_d = 1'b0;
            end
         end
         default: st_d = LS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= LS_IDLE;
         lock_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         lock_q <= lock_d;
      end
   end

   assign lock_o = lock_q;
   assign busy_o = (st_q != LS_IDLE);
endmodule

// File: rtl/lha_req_arb.sv
module lha_req_arb #(
   parameter bit RFSH_OVER_HOLD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic idle_i,
   input  logic hold_req_i,
   input  logic rfsh_req_i,
   output logic hlda_o,
   output logic rfsh_gnt_o
);
   logic hold_pend_q, rfsh_pend_q;
   logic hlda_q, rgnt_q;
   logic can_grant, hold_live, hg_now, rg_now;

   assign can_grant = !busy_i && idle_i && !hlda_q && !rgnt_q;
   assign hold_live = hold_pend_q && hold_req_i;

   generate
      if (RFSH_OVER_HOLD) begin : g_rfsh_first
         assign rg_now = can_grant && rfsh_pend_q;
         assign hg_now = can_grant && hold_live && !rfsh_pend_q;
      end else begin : g_hold_first
         assign hg_now = can_grant && hold_live;
         assign rg_now = can_grant && rfsh_pend_q && !hold_live;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_pend_q <= 1'b0;
         rfsh_pend_q <= 1'b0;
         hlda_q      <= 1'b0;
         rgnt_q      <= 1'b0;
      end else begin
         hold_pend_q <= hold_req_i && !hlda_q && !hg_now;
         rfsh_pend_q <= rfsh_req_i || (rfsh_pend_q && !rg_now);
         hlda_q      <= hold_req_i && (hlda_q || hg_now);
         rgnt_q      <= rg_now;
      end
   end

   assign hlda_o     = hlda_q;
   assign rfsh_gnt_o = rgnt_q;
endmodule

// File: rtl/lock_hold_arbiter.sv
module lock_hold_arbiter #(
   parameter int RFSH_OVER_HOLD = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_pfx_i,
   input  logic instr_end_i,
   input  logic t1_i,
   input  logic ph1_i,
   input  logic bus_idle_i,
   input  logic halt_i,
   input  logic intr_i,
   input  logic hold_req_i,
   input  logic rfsh_req_i,
   output logic lock_o,
   output logic hlda_o,
   output logic rfsh_gnt_o,
   output logic wake_o
);
   localparam bit PRIO_RFSH = (RFSH_OVER_HOLD != 0);

   initial begin
      assert (RFSH_OVER_HOLD == 0 || RFSH_OVER_HOLD == 1)
         else $error("RFSH_OVER_HOLD must be 0 or 1");
   end

   logic t1_edge;
   logic lock_busy;

   assign t1_edge = t1_i && ph1_i;

   lha_lock_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pfx_i  (lock_pfx_i),
      .end_i  (instr_end_i),
      .edge_i (t1_edge),
      .lock_o (lock_o),
      .busy_o (lock_busy)
   );

   lha_req_arb #(.RFSH_OVER_HOLD(PRIO_RFSH)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (lock_busy),
      .idle_i     (bus_idle_i),
      .hold_req_i (hold_req_i),
      .rfsh_req_i (rfsh_req_i),
      .hlda_o     (hlda_o),
      .rfsh_gnt_o (rfsh_gnt_o)
   );

   // Interrupts bypass the lock entirely.
   assign wake_o = halt_i && intr_i;
endmodule

// File: rtl/lha_checker.sv
module lha_checker (
   input logic clk,
   input logic rst_n,
   input logic t1_i,
   input logic ph1_i,
   input logic bus_idle_i,
   input logic hold_req_i,
   input logic lock_o,
   input logic hlda_o,
   input logic rfsh_gnt_o
);
   p_lock_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(t1_i && ph1_i));

   p_lock_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_o) |-> $past(t1_i && ph1_i));

   p_no_grant_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> (!rfsh_gnt_o && !$rose(hlda_o)));

   p_rgnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_gnt_o |-> $past(bus_idle_i));

   p_hlda_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda_o) |-> $past(bus_idle_i));

   p_rgnt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_gnt_o |=> !rfsh_gnt_o);

   p_hold_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_req_i |=> !hlda_o);

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(hlda_o && rfsh_gnt_o));

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_r10: assert (!lock_o && !hlda_o && !rfsh_gnt_o);
      end
   end
endmodule

bind lock_hold_arbiter lha_checker u_lha_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .t1_i       (t1_i),
   .ph1_i      (ph1_i),
   .bus_idle_i (bus_idle_i),
   .hold_req_i (hold_req_i),
   .lock_o     (lock_o),
   .hlda_o     (hlda_o),
   .rfsh_gnt_o (rfsh_gnt_o)
);

// File: tb/tb_lock_hold_arbiter.sv
module tb_lock_hold_arbiter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pfx = 0, iend = 0, t1 = 0, ph1 = 0, idle = 1, halt = 0, intr = 0;
   logic hreq = 0, rreq = 0;
   logic lock, hlda, rgnt, wake;
   logic lock_a, hlda_a, rgnt_a, wake_a;
   int   n_chk = 0;
   int   n_err = 0;
   bit   finished = 0;

   always #5 clk = ~clk;

   lock_hold_arbiter #(.RFSH_OVER_HOLD(1)) dut (
      .clk(clk), .rst_n(rst_n), .lock_pfx_i(pfx), .instr_end_i(iend),
      .t1_i(t1), .ph1_i(ph1), .bus_idle_i(idle), .halt_i(halt),
      .intr_i(intr), .hold_req_i(hreq), .rfsh_req_i(rreq),
      .lock_o(lock), .hlda_o(hlda), .rfsh_gnt_o(rgnt), .wake_o(wake));

   lock_hold_arbiter #(.RFSH_OVER_HOLD(0)) dut_alt (
      .clk(clk), .rst_n(rst_n), .lock_pfx_i(pfx), .instr_end_i(iend),
      .t1_i(t1), .ph1_i(ph1), .bus_idle_i(idle), .halt_i(halt),
      .intr_i(intr), .hold_req_i(hreq), .rfsh_req_i(rreq),
      .lock_o(lock_a), .hlda_o(hlda_a), .rfsh_gnt_o(rgnt_a), .wake_o(wake_a));

   // Row: {pfx,iend,t1,ph1,idle,halt,intr,hreq,rreq} _ {lock,hlda,rgnt,wake}
   localparam int NV = 43;
   localparam logic [12:0] VEC [0:NV-1] = '{
      13'b000010000_0000, 13'b100010000_0000, 13'b001010000_0000, // R1
      13'b001100000_1000, 13'b000100010_1000, 13'b000010011_1000, // R5
      13'b010010010_1000, 13'b000010010_1000, 13'b001100010_0000, // R2
      13'b000010010_0010, 13'b000010010_0000, 13'b000010010_0100, // R6 R5
      13'b000010010_0100, 13'b000010000_0000, 13'b100010000_0000, // R8
      13'b001100000_1000, 13'b000011010_1000, 13'b000011110_1001, // R9
      13'b010010010_1000, 13'b001100010_0000, 13'b000010010_0100,
      13'b000010000_0000, 13'b100010000_0000, 13'b001100000_1000,
      13'b000010010_1000, 13'b000010000_1000, 13'b010010000_1000, // R8
      13'b001100000_0000, 13'b000010000_0000, 13'b100010000_0000,
      13'b010010000_0000, 13'b001100000_0000, 13'b100010000_0000, // R3
      13'b001100000_1000, 13'b010010000_1000, 13'b100010000_1000, // R4
      13'b001100000_1000, 13'b010010000_1000, 13'b001100000_0000,
      13'b000000001_0000, 13'b000000000_0000, 13'b000010000_0010, // R7
      13'b000010000_0000
   };

   task automatic chk(input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
      end
   endtask

   task automatic drive(input logic [8:0] v);
      {pfx, iend, t1, ph1, idle, halt, intr, hreq, rreq} = v;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      drive(9'b000010000);
      repeat (3) tick();
      // R10: reset state
      chk("R10 lock in reset", lock, 1'b0);
      chk("R10 hlda in reset", hlda, 1'b0);
      chk("R10 rgnt in reset", rgnt, 1'b0);
      rst_n = 1'b1;
      tick();

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][12:4]);
         tick();
         chk($sformatf("R1 R2 R3 R4 lock row %0d", i), lock, VEC[i][3]);
         chk($sformatf("R5 R8 hlda row %0d", i), hlda, VEC[i][2]);
         chk($sformatf("R5 R6 R7 rgnt row %0d", i), rgnt, VEC[i][1]);
         chk($sformatf("R9 wake row %0d", i), wake, VEC[i][0]);
      end

      // R10: reset in the middle of a locked instruction with a pending hold
      drive(9'b100010000); tick();
      drive(9'b001100000); tick();
      chk("R10 lock set before reset", lock, 1'b1);
      drive(9'b000010010); tick();
      rst_n = 1'b0;
      #1;
      chk("R10 lock cleared by reset", lock, 1'b0);
      chk("R10 hlda cleared by reset", hlda, 1'b0);
      drive(9'b000010000);
      tick(); tick();
      rst_n = 1'b1;
      drive(9'b000010010); tick();
      chk("R10 no lock after reset", lock, 1'b0);
      chk("R10 pending hold cleared", hlda, 1'b0);
      drive(9'b000010000); tick();

      // R6: both pending together, both priority orders
      drive(9'b000000011); tick();          // idle low: both recorded
      drive(9'b000010010); tick();          // E1
      chk("R6 refresh first (default)", rgnt, 1'b1);
      chk("R6 no hold yet (default)", hlda, 1'b0);
      chk("R6 hold first (alt)", hlda_a, 1'b1);
      chk("R6 refresh waits (alt)", rgnt_a, 1'b0);
      tick();                               // E2
      chk("R7 refresh pulse ends", rgnt, 1'b0);
      tick();                               // E3
      chk("R6 hold after refresh (default)", hlda, 1'b1);
      drive(9'b000010000); tick();          // E4
      chk("R8 hold released (alt)", hlda_a, 1'b0);
      chk("R6 refresh still waiting (alt)", rgnt_a, 1'b0);
      tick();                               // E5
      chk("R6 refresh after hold (alt)", rgnt_a, 1'b1);
      chk("R11 no hold with refresh (alt)", hlda_a, 1'b0);
      tick();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule